// File: doc/BRIEF.md
# Strobe Signal to Port Router

This block takes a wide vector of internal timing strobes and steers any chosen subset of them onto a handful of external strobe pins. A per-signal configuration table decides which pin, if any, each strobe is routed to. When several strobes share a pin they are OR-merged. A pin with no routed strobe stays low. The pins are registered, so every strobe reaches its pin after exactly one clock, whichever pin it uses. Relative strobe timing therefore survives the routing.

Software programs the table through one 16-bit control word using indirect access. A write names one strobe by its index and supplies that strobe's enable and destination pin. Only that strobe's table entry is replaced. A read of the control word shows the entry of the strobe that was written last. The word may be written at any time, including while the strobes are toggling.

A single-channel mode input marks the upper half of the strobe vector as meaningless. In that mode those strobes are forced low before the merge, so they cannot disturb any pin.

Top module: `strobe_port_router`

## Requirements
- R1: After reset every table entry is disabled, every pin `strobe_out` bit is 0 and `rd_data` reads 0, whatever `strobe_in` carries.
- R2: A full write (`wr_en` high with `wr_be` = 2'b11) carries the strobe index in `wr_data[5:0]`, the destination pin in `wr_data[9:8]` and the enable in `wr_data[15]`. It replaces the table entry of that one strobe only; all other entries keep their values.
- R3: A write with `wr_be` other than 2'b11 changes neither the table nor `rd_data`.
- R4: `rd_data` shows the stored entry of the most recently fully written index: the enable in bit 15, the pin in bits 9:8 and the index in bits 5:0, with all other bits 0.
- R5: Each pin bit of `strobe_out` equals, one clock later, the OR of the current values of all enabled strobes routed to that pin. The latency is the same for every strobe and pin.
- R6: A pin with no enabled strobe routed to it outputs 0 on the following cycle.
- R7: A full write with the enable bit clear removes that strobe from every pin, whatever pin value the write carries.
- R8: While `single_chan` is high, strobes with index at or above NUM_SIG/2 are treated as 0 on every pin.
- R9: A strobe feeds at most one pin. Rewriting its entry with a new pin moves it, and the old pin no longer sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_be | input | 2 | Byte enables of the write; both must be set |
| wr_data | input | 16 | Control word write data |
| rd_data | output | 16 | Entry of the last written strobe |
| single_chan | input | 1 | Single-channel mode; masks the upper-half strobes |
| strobe_in | input | NUM_SIG | Internal strobe signals |
| strobe_out | output | NUM_PORT | Merged, registered strobe pins |

## Verification
The assertions assume that a write always carries an index below NUM_SIG. They also assume that `strobe_in`, `single_chan` and the write inputs are stable around the rising clock edge. The bench drives every input on the falling edge. It draws indices only from the legal range, and it draws pins only from the two-bit field. Narrow writes are sent with legal-looking field contents, so that ignoring them is visible at `rd_data` and on the pins.

// File: rtl/strobe_router_pkg.sv
package strobe_router_pkg;

  localparam int CTRL_W   = 16;
  localparam int EN_POS   = 15;
  localparam int PORT_LSB = 8;
  localparam int IDX_LSB  = 0;

  // field extraction, fixed 8-bit results; callers size them down
  function automatic logic [7:0] ctrl_index(input logic [CTRL_W-1:0] d);
    return {2'b00, d[IDX_LSB +: 6]};
  endfunction

  function automatic logic [7:0] ctrl_port(input logic [CTRL_W-1:0] d);
    return {2'b00, d[PORT_LSB +: 6]};
  endfunction

  function automatic logic ctrl_enable(input logic [CTRL_W-1:0] d);
    return d[EN_POS];
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_pack(input logic en,
                                                   input logic [7:0] port,
                                                   input logic [7:0] idx);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[EN_POS] = en;
    w[PORT_LSB +: 6] = port[5:0];
    w[IDX_LSB +: 6] = idx[5:0];
    return w;
  endfunction

endpackage

// File: rtl/strobe_cfg_table.sv
module strobe_cfg_table #(
  parameter int NUM_SIG = 64,
  parameter int SEL_W   = 6,
  parameter int PSEL_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd,
  input  logic [SEL_W-1:0]          upd_idx,
  input  logic                      upd_en,
  input  logic [PSEL_W-1:0]         upd_port,
  output logic [NUM_SIG-1:0]        en_vec,
  output logic [NUM_SIG*PSEL_W-1:0] port_flat,
  output logic [NUM_SIG-1:0]        entry_we
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SIG; gi++) begin : g_entry
      assign entry_we[gi] = upd && (upd_idx == SEL_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_vec[gi]                    <= 1'b0;
          port_flat[gi*PSEL_W +: PSEL_W] <= '0;
        end else if (entry_we[gi]) begin
          en_vec[gi]                    <= upd_en;
          port_flat[gi*PSEL_W +: PSEL_W] <= upd_port;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/strobe_port_merge.sv
module strobe_port_merge #(
  parameter int NUM_SIG  = 64,
  parameter int NUM_PORT = 4,
  parameter int PSEL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SIG-1:0]        sig_in,
  input  logic [NUM_SIG-1:0]        en_vec,
  input  logic [NUM_SIG*PSEL_W-1:0] port_flat,
  output logic [NUM_PORT-1:0]       port_out,
  output logic [NUM_PORT-1:0]       port_has_src
);

  logic [NUM_PORT-1:0] merged;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORT; gp++) begin : g_port
      always_comb begin
        merged[gp]       = 1'b0;
        port_has_src[gp] = 1'b0;
        for (int s = 0; s < NUM_SIG; s++) begin
          if (en_vec[s] && (port_flat[s*PSEL_W +: PSEL_W] == PSEL_W'(gp))) begin
            port_has_src[gp] = 1'b1;
            merged[gp]       = merged[gp] | sig_in[s];
          end
        end
      end
    end
  endgenerate

  // single register stage for all pins: equal latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_out <= '0;
    else        port_out <= merged;
  end

endmodule

// File: rtl/strobe_port_router.sv
module strobe_port_router
  import strobe_router_pkg::*;
#(
  parameter int NUM_SIG  = 64,
  parameter int NUM_PORT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_be,
  input  logic [15:0]         wr_data,
  output logic [15:0]         rd_data,
  input  logic                single_chan,
  input  logic [NUM_SIG-1:0]  strobe_in,
  output logic [NUM_PORT-1:0] strobe_out
);

  localparam int SEL_W    = (NUM_SIG  > 1) ? $clog2(NUM_SIG)  : 1;
  localparam int PSEL_W   = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;
  localparam int CHB_BASE = NUM_SIG / 2;

  logic                      full_wr;
  logic [SEL_W-1:0]          wr_idx;
  logic [PSEL_W-1:0]         wr_port;
  logic                      wr_enable;
  logic [SEL_W-1:0]          last_idx;
  logic [NUM_SIG-1:0]        en_vec;
  logic [NUM_SIG*PSEL_W-1:0] port_flat;
  logic [NUM_SIG-1:0]        entry_we;
  logic [NUM_SIG-1:0]        chb_mask;
  logic [NUM_SIG-1:0]        eff_in;
  logic [NUM_PORT-1:0]       port_has_src;

  assign full_wr   = wr_en && (wr_be == 2'b11);
  assign wr_idx    = SEL_W'(ctrl_index(wr_data));
  assign wr_port   = PSEL_W'(ctrl_port(wr_data));
  assign wr_enable = ctrl_enable(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_idx <= '0;
    else if (full_wr) last_idx <= wr_idx;
  end

  always_comb begin
    rd_data = '0;
    if (int'(last_idx) < NUM_SIG)
      rd_data = ctrl_pack(en_vec[last_idx],
                          8'(port_flat[int'(last_idx)*PSEL_W +: PSEL_W]),
                          8'(last_idx));
  end

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SIG; gs++) begin : g_chb
      if (gs >= CHB_BASE) begin : g_b
        assign chb_mask[gs] = 1'b1;
      end else begin : g_a
        assign chb_mask[gs] = 1'b0;
      end
    end
  endgenerate

  assign eff_in = single_chan ? (strobe_in & ~chb_mask) : strobe_in;

  strobe_cfg_table #(
    .NUM_SIG(NUM_SIG), .SEL_W(SEL_W), .PSEL_W(PSEL_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .upd(full_wr), .upd_idx(wr_idx),
    .upd_en(wr_enable), .upd_port(wr_port),
    .en_vec(en_vec), .port_flat(port_flat), .entry_we(entry_we)
  );

  strobe_port_merge #(
    .NUM_SIG(NUM_SIG), .NUM_PORT(NUM_PORT), .PSEL_W(PSEL_W)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .sig_in(eff_in), .en_vec(en_vec),
    .port_flat(port_flat), .port_out(strobe_out), .port_has_src(port_has_src)
  );

endmodule

// File: rtl/strobe_router_chk.sv
module strobe_router_chk #(
  parameter int NUM_SIG  = 64,
  parameter int NUM_PORT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_be,
  input logic [15:0]         wr_data,
  input logic [15:0]         rd_data,
  input logic                single_chan,
  input logic [NUM_SIG-1:0]  strobe_in,
  input logic [NUM_PORT-1:0] strobe_out,
  input logic [NUM_SIG-1:0]  eff_in,
  input logic [NUM_PORT-1:0] port_has_src,
  input logic [NUM_SIG-1:0]  entry_we
);

  localparam int SEL_W  = (NUM_SIG  > 1) ? $clog2(NUM_SIG)  : 1;
  localparam int PSEL_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;
  localparam logic [15:0] FIELD_MASK =
    16'h8000 | 16'((32'(1) << PSEL_W) - 1) << 8 | 16'((32'(1) << SEL_W) - 1);
  localparam int HALF = NUM_SIG / 2;

  logic full_wr;
  logic narrow_wr;
  assign full_wr   = wr_en && (wr_be == 2'b11);
  assign narrow_wr = wr_en && (wr_be != 2'b11);

  // R2: a write touches at most one entry
  assert_single_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_we));

  // R3: narrow writes update nothing
  assert_narrow_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_wr |-> (entry_we == '0));

  // R4: read-back follows the last full write
  assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr |=> (rd_data == ($past(wr_data) & FIELD_MASK)));

  // R5: a pin can only be high if some strobe was high a cycle earlier
  assert_out_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe_out) |-> $past(|strobe_in));

  // R6: pins without sources stay low
  assert_empty_port_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_out & ~$past(port_has_src)) == '0);

  // R7: disable write shows cleared enable
  assert_disable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && !wr_data[15]) |=> !rd_data[15]);

  // R8: upper-half strobes never reach the merge in single-channel mode
  assert_chb_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    single_chan |-> ((eff_in >> HALF) == '0));

endmodule

bind strobe_port_router strobe_router_chk #(
  .NUM_SIG(NUM_SIG), .NUM_PORT(NUM_PORT)
) u_chk (.*);

// File: tb/strobe_port_router_test.sv
module strobe_port_router_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 64;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_be = 2'b00;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          single_chan = 1'b0;
  logic [NS-1:0] strobe_in = '0;
  logic [NP-1:0] strobe_out;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  // reference model state
  bit       m_en   [NS];
  int       m_port [NS];
  int       m_last = 0;
  logic [NP-1:0] m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_port_router #(.NUM_SIG(NS), .NUM_PORT(NP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .single_chan(single_chan), .strobe_in(strobe_in),
    .strobe_out(strobe_out)
  );

  function automatic logic [15:0] enc(bit en, int port, int idx);
    return (en ? 16'h8000 : 16'h0) | 16'((port % 4) * 256) | 16'(idx % 64);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin m_en[s] = 0; m_port[s] = 0; end
      m_last = 0;
      m_out  = '0;
    end else begin
      logic [NP-1:0] nxt;
      nxt = '0;
      for (int s = 0; s < NS; s++)
        if (m_en[s] && strobe_in[s] && !(single_chan && s >= NS/2))
          nxt[m_port[s]] = 1'b1;
      m_out = nxt;
      if (wr_en && wr_be == 2'b11) begin
        int ix;
        ix = int'(wr_data[5:0]);
        m_en[ix]   = wr_data[15];
        m_port[ix] = int'(wr_data[9:8]);
        m_last     = ix;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] exp_rd;
    cycles++;
    exp_rd = enc(m_en[m_last], m_port[m_last], m_last);
    tests++;
    if (strobe_out !== m_out || rd_data !== exp_rd) begin
      fails++;
      $display("FAIL %s cycle %0d: out=%b rd=%h expected out=%b rd=%h (R5 model)",
               phase, cycles, strobe_out, rd_data, m_out, exp_rd);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic write_word(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check(string tag, logic [NP-1:0] exp_out, logic [15:0] exp_rd);
    tests++;
    if (strobe_out !== exp_out || rd_data !== exp_rd) begin
      fails++;
      $display("FAIL %s: out=%b rd=%h expected out=%b rd=%h",
               tag, strobe_out, rd_data, exp_out, exp_rd);
    end
  endtask

  initial begin
    strobe_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 reset state", 4'b0000, 16'h0000);

    phase = "R2";
    write_word(enc(1, 1, 3), 2'b11);
    write_word(enc(1, 1, 10), 2'b11);
    write_word(enc(1, 2, 20), 2'b11);
    strobe_in = '0; strobe_in[10] = 1'b1;
    settle();
    check("R5 merge from one source", 4'b0010, 16'h8214);

    phase = "R6";
    strobe_in = '1;
    settle();
    check("R6 unmapped pins low", 4'b0110, 16'h8214);
    check("R4 readback", 4'b0110, 16'h8214);

    phase = "R3";
    write_word(enc(0, 3, 20), 2'b01);
    write_word(enc(0, 3, 20), 2'b10);
    settle();
    check("R3 narrow write ignored", 4'b0110, 16'h8214);

    phase = "R7";
    write_word(enc(0, 3, 20), 2'b11);
    settle();
    check("R7 disable ignores pin", 4'b0010, 16'h0314);

    phase = "R9";
    write_word(enc(1, 0, 3), 2'b11);
    strobe_in = '0; strobe_in[3] = 1'b1;
    settle();
    check("R9 strobe moved", 4'b0001, 16'h8003);

    phase = "R8";
    write_word(enc(1, 3, 40), 2'b11);
    strobe_in = '0; strobe_in[40] = 1'b1;
    settle();
    check("R8 upper half passes normally", 4'b1000, 16'h8328);
    single_chan = 1'b1;
    settle();
    check("R8 upper half forced low", 4'b0000, 16'h8328);
    single_chan = 1'b0;

    phase = "R5 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      strobe_in   = {$urandom, $urandom};
      single_chan = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) begin
        wr_en   = 1'b1;
        wr_be   = (($urandom % 5) == 0) ? 2'($urandom % 3) : 2'b11;
        wr_data = enc(($urandom % 3) != 0, int'($urandom % 4), int'($urandom % 64));
      end else begin
        wr_en = 1'b0;
        wr_be = 2'b00;
      end
    end
    wr_en = 1'b0;
    settle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule